// File: doc/BRIEF.md
# Multi-Lane Serial Bus Width Controller

This block is the bus-facing front end of a serial memory slave whose data path can run one, two or four lanes wide. It watches the chip select and the serial clock, gathers 1, 2 or 4 bits per serial clock into bytes, and hands each finished byte to the command engine behind it. Going the other way, it takes bytes from the engine and shifts them out on the lanes while driving the matching output enables. Address decoding and address sequencing stay in the engine.

The lane width changes at run time through in-band commands placed in the first byte of a frame. When the bus is one lane wide, 0x3B widens it to two lanes and 0x38 widens it to four. From either wide setting, 0xFF sent at the current width returns the bus to one lane. The width register survives chip-select cycles. At the wide settings one byte slot of clocks follows the two address bytes before any read data is driven. Every frame is an 8-bit instruction, then two address bytes, then data.

The serial inputs are sampled on the block clock `clk`. They are assumed to be already synchronised to it and to change slowly enough that each serial clock level lasts at least two `clk` cycles. Both serial clock edges are detected from a registered copy of `sck`. The receive stream has a valid strobe but no ready: the serial bus cannot be paused, so the engine must accept every `rx_valid` pulse. The transmit stream uses a valid/ready handshake. `tx_ready` is a one-cycle pulse at each byte boundary where read data may start. A byte is transferred only in a cycle where `tx_valid` and `tx_ready` are both high. If `tx_valid` is low at that boundary, the lanes stay released for the whole of that byte slot.

Top module: `mlane_if`

## Requirements
- R1: After reset the width is one lane (`lane_mode` = 0, where 0 means one lane, 1 means two lanes and 2 means four lanes), every `lane_oe` bit is 0 and `rx_valid` is low.
- R2: At one-lane width, each byte is taken MSB first from `lane_in[0]`, one bit per rising edge of `sck`. Every completed byte, dummy slots included, gives exactly one `rx_valid` pulse with that byte on `rx_data`.
- R3: At two-lane width, each rising edge takes two bits and `lane_in[1]` holds the higher bit of the pair, so four clocks make a byte. At four-lane width, each rising edge takes a nibble with `lane_in[3]` as its MSB, upper nibble first, so two clocks make a byte. Outgoing bits use the same lane order.
- R4: At one-lane width, a first frame byte of 0x3B selects two lanes and 0x38 selects four lanes, starting with the next byte. The same values in any later byte of the frame leave the width unchanged.
- R5: At either wide width, a first frame byte of 0xFF, sent at that width, selects one lane. Any other first byte, 0x3B and 0x38 included, leaves the width unchanged. At one-lane width, 0xFF has no effect on the width.
- R6: The width is kept when chip select goes high and applies to the next frame.
- R7: While `cs_n` is high, all `lane_oe` bits are 0 from the next clock on. A partial byte is dropped without an `rx_valid` pulse, and the next frame starts at bit 0.
- R8: At one-lane width, read data may start at byte slot 3, right after the instruction and two address bytes. It leaves MSB first on `lane_out[1]` with only `lane_oe[1]` set. It changes after the falling edge of `sck`, and `lane_in[0]` is never driven.
- R9: At two-lane and four-lane widths, slot 3 is a dummy byte: no `tx_ready` pulse is given and the lanes stay released. Read data starts at slot 4, with `lane_oe` equal to 4'b0011 or 4'b1111 respectively.
- R10: When `tx_valid` is low at a byte boundary, that byte slot drives no lane. This covers writes, where every `lane_oe` bit stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock used to sample the serial bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| lane_in | input | 4 | Input values of the four data lanes |
| lane_out | output | 4 | Output values of the four data lanes |
| lane_oe | output | 4 | Per-lane output enable |
| lane_mode | output | 2 | Current width: 0 one lane, 1 two lanes, 2 four lanes |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| tx_valid | input | 1 | Engine offers a byte to transmit |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Pulse at a boundary where a transmit byte is taken |

## Verification
The bench sweeps every byte value through both the receive path and the transmit path at all three widths. A lane or bit-order mistake, such as swapping the two lanes of a pair or sending the lower nibble first, corrupts almost every value in these sweeps. It checks that the mode commands act only in the first byte and only at the width where they are legal. A decoder that looks at every byte would widen the bus on a data byte, and one that honours 0x38 while already wide would change width when it should not. It cuts frames in the middle of a byte and then sends an exit command. A counter that is not cleared on deselect would misalign that command and leave the bus stuck wide. It also checks that no lane is driven during the instruction, address and dummy slots, or during writes, and that the lanes are released at once when a read is cut off. Either fault would show up as bus contention.

// File: rtl/mlane_pkg.sv
package mlane_pkg;

  typedef enum logic [1:0] {
    W_SINGLE = 2'd0,
    W_DUAL   = 2'd1,
    W_QUAD   = 2'd2
  } width_e;

  localparam logic [7:0] CMD_GO_DUAL   = 8'h3B;
  localparam logic [7:0] CMD_GO_QUAD   = 8'h38;
  localparam logic [7:0] CMD_GO_SINGLE = 8'hFF;

  function automatic logic [2:0] bits_per_clk(width_e w);
    case (w)
      W_DUAL:  return 3'd2;
      W_QUAD:  return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(width_e w);
    case (w)
      W_DUAL:  return 4'b0011;
      W_QUAD:  return 4'b1111;
      default: return 4'b0010;
    endcase
  endfunction

endpackage

// File: rtl/mlane_rx_deser.sv
module mlane_rx_deser
  import mlane_pkg::*;
#(
  parameter int SLOT_MAX = 4,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck_rise,
  input  width_e           width,
  input  logic [3:0]       lane_in,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_first,
  output logic             at_boundary,
  output logic [IDX_W-1:0] byte_idx
);

  localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(SLOT_MAX);

  logic [7:0] sh_q, sh_nxt;
  logic [2:0] bcnt_q;
  logic [2:0] step;
  logic [3:0] sum;
  logic       done;

  assign step = bits_per_clk(width);
  assign sum  = {1'b0, bcnt_q} + {1'b0, step};
  assign done = (sum == 4'd8);
  assign at_boundary = (bcnt_q == 3'd0);

  always_comb begin
    case (width)
      W_DUAL:  sh_nxt = {sh_q[5:0], lane_in[1:0]};
      W_QUAD:  sh_nxt = {sh_q[3:0], lane_in};
      default: sh_nxt = {sh_q[6:0], lane_in[0]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      bcnt_q   <= '0;
      byte_idx <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_first <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (cs_n) begin
        bcnt_q   <= '0;
        byte_idx <= '0;
      end else if (sck_rise) begin
        sh_q <= sh_nxt;
        if (done) begin
          bcnt_q   <= '0;
          rx_data  <= sh_nxt;
          rx_valid <= 1'b1;
          rx_first <= (byte_idx == '0);
          if (byte_idx != IDX_SAT) byte_idx <= byte_idx + 1'b1;
        end else begin
          bcnt_q <= sum[2:0];
        end
      end
    end
  end

  AST_STROBE_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(sck_rise)); // R2

  AST_COUNT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ((bcnt_q & (step - 3'd1)) == 3'd0)); // R3

endmodule

// File: rtl/mlane_width_ctl.sv
module mlane_width_ctl
  import mlane_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic       rx_first,
  input  logic [7:0] rx_data,
  output width_e     width
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width <= W_SINGLE;
    end else if (rx_valid && rx_first) begin
      case (width)
        W_SINGLE: begin
          if (rx_data == CMD_GO_DUAL)      width <= W_DUAL;
          else if (rx_data == CMD_GO_QUAD) width <= W_QUAD;
        end
        default: begin
          if (rx_data == CMD_GO_SINGLE) width <= W_SINGLE;
        end
      endcase
    end
  end

  AST_WIDTH_ON_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(width) |-> $past(rx_valid && rx_first)); // R4

  AST_WIDE_EXITS_TO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(width) && ($past(width) != W_SINGLE)) |-> (width == W_SINGLE)); // R5

endmodule

// File: rtl/mlane_tx_ser.sv
module mlane_tx_ser
  import mlane_pkg::*;
#(
  parameter int NARROW_SLOT = 3,
  parameter int WIDE_SLOT   = 4,
  parameter int IDX_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck_fall,
  input  logic             at_boundary,
  input  logic [IDX_W-1:0] byte_idx,
  input  width_e           width,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic [3:0]       lane_out,
  output logic [3:0]       lane_oe
);

  localparam logic [IDX_W-1:0] SLOT_N = IDX_W'(NARROW_SLOT);
  localparam logic [IDX_W-1:0] SLOT_W = IDX_W'(WIDE_SLOT);

  logic [7:0] sh_q;
  logic       active_q;
  logic       slot_ok;

  assign slot_ok  = (width == W_SINGLE) ? (byte_idx >= SLOT_N) : (byte_idx >= SLOT_W);
  assign tx_ready = sck_fall && at_boundary && slot_ok && !cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      active_q <= 1'b0;
    end else if (cs_n) begin
      active_q <= 1'b0;
    end else if (sck_fall) begin
      if (at_boundary) begin
        if (tx_valid && tx_ready) begin
          sh_q     <= tx_data;
          active_q <= 1'b1;
        end else begin
          active_q <= 1'b0;
        end
      end else begin
        case (width)
          W_DUAL:  sh_q <= {sh_q[5:0], 2'b00};
          W_QUAD:  sh_q <= {sh_q[3:0], 4'h0};
          default: sh_q <= {sh_q[6:0], 1'b0};
        endcase
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    always_comb begin
      case (width)
        W_QUAD:  lane_out[g] = sh_q[4+g];
        W_DUAL:  lane_out[g] = (g < 2) ? sh_q[6+(g%2)] : 1'b0;
        default: lane_out[g] = (g == 1) ? sh_q[7] : 1'b0;
      endcase
    end
  end

  assign lane_oe = active_q ? lane_mask(width) : 4'b0000;

  AST_NO_EARLY_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(slot_ok)); // R9

  AST_SINGLE_IN_LANE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (width == W_SINGLE) |-> !lane_oe[0]); // R8

endmodule

// File: rtl/mlane_if.sv
module mlane_if
  import mlane_pkg::*;
#(
  parameter int CMD_BYTES   = 1,
  parameter int ADDR_BYTES  = 2,
  parameter int DUMMY_BYTES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic [3:0] lane_in,
  output logic [3:0] lane_out,
  output logic [3:0] lane_oe,
  output logic [1:0] lane_mode,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready
);

  localparam int SLOT_NARROW = CMD_BYTES + ADDR_BYTES;
  localparam int SLOT_WIDE   = SLOT_NARROW + DUMMY_BYTES;
  localparam int IDX_W       = $clog2(SLOT_WIDE + 1);

  logic             sck_q;
  logic             sck_rise, sck_fall;
  logic             rx_first, at_boundary;
  logic [IDX_W-1:0] byte_idx;
  width_e           width;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  assign sck_rise  = sck && !sck_q && !cs_n;
  assign sck_fall  = !sck && sck_q && !cs_n;
  assign lane_mode = width;

  mlane_rx_deser #(.SLOT_MAX(SLOT_WIDE), .IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise), .width(width),
    .lane_in(lane_in), .rx_valid(rx_valid), .rx_data(rx_data), .rx_first(rx_first),
    .at_boundary(at_boundary), .byte_idx(byte_idx)
  );

  mlane_width_ctl u_width (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first),
    .rx_data(rx_data), .width(width)
  );

  mlane_tx_ser #(.NARROW_SLOT(SLOT_NARROW), .WIDE_SLOT(SLOT_WIDE), .IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_fall(sck_fall), .at_boundary(at_boundary),
    .byte_idx(byte_idx), .width(width), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .lane_out(lane_out), .lane_oe(lane_oe)
  );

  AST_RELEASE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (lane_oe == 4'b0000)); // R7

  AST_NO_RX_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !rx_valid); // R7

endmodule

// File: tb/tb_mlane_if.sv
module tb_mlane_if;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, sck, tx_valid, tx_ready, rx_valid;
  logic [3:0] lane_in, lane_out, lane_oe;
  logic [1:0] lane_mode;
  logic [7:0] rx_data, tx_data;

  int checks = 0;
  int fails  = 0;
  int rx_total = 0;
  logic [7:0] rxq [0:4095];
  logic [7:0] fbuf [0:299];
  int flen;

  always #5 clk = ~clk;

  mlane_if dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .lane_in(lane_in),
    .lane_out(lane_out), .lane_oe(lane_oe), .lane_mode(lane_mode),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rxq[rx_total] = rx_data;
      rx_total++;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] mask_of(input int w);
    if (w == 1) return 4'b0010;
    if (w == 2) return 4'b0011;
    return 4'b1111;
  endfunction

  task automatic pulse(input logic [3:0] v, output logic [3:0] o, output logic [3:0] e);
    lane_in = v;
    repeat (2) @(negedge clk);
    o = lane_out;
    e = lane_oe;
    sck = 1'b1;
    repeat (3) @(negedge clk);
    sck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b, input int w, input logic [3:0] exp_oe,
                      output logic [7:0] got, output logic oe_bad);
    logic [7:0] tmp;
    logic [3:0] v, o, e;
    tmp = b; got = 8'h00; oe_bad = 1'b0;
    for (int k = 0; k < 8 / w; k++) begin
      if (w == 1)      v = {3'b000, tmp[7]};
      else if (w == 2) v = {2'b00, tmp[7:6]};
      else             v = tmp[7:4];
      if (w == 1)      tmp = {tmp[6:0], 1'b0};
      else if (w == 2) tmp = {tmp[5:0], 2'b00};
      else             tmp = {tmp[3:0], 4'h0};
      pulse(v, o, e);
      if (w == 1)      got = {got[6:0], o[1]};
      else if (w == 2) got = {got[5:0], o[1:0]};
      else             got = {got[3:0], o};
      if (e !== exp_oe) oe_bad = 1'b1;
    end
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_end();
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_frame(input int w, input string tag);
    logic [7:0] g;
    logic ob, any_bad;
    int base;
    tx_valid = 1'b0;
    base = rx_total;
    any_bad = 1'b0;
    cs_begin();
    for (int i = 0; i < flen; i++) begin
      xfer(fbuf[i], w, 4'h0, g, ob);
      any_bad |= ob;
    end
    cs_end();
    chk(!any_bad, "R10 lanes driven during write", 32'(any_bad), 32'h0);
    chk(rx_total - base == flen, tag, 32'(rx_total - base), 32'(flen));
    for (int i = 0; i < flen; i++)
      chk(rxq[base+i] == fbuf[i], tag, 32'(rxq[base+i]), 32'(fbuf[i]));
  endtask

  task automatic read_frame(input int w, input string tag);
    logic [7:0] g;
    logic ob, pre_bad;
    pre_bad = 1'b0;
    tx_valid = 1'b1;
    tx_data = 8'h00;
    cs_begin();
    xfer(8'h03, w, 4'h0, g, ob); pre_bad |= ob;
    xfer(8'h12, w, 4'h0, g, ob); pre_bad |= ob;
    xfer(8'h34, w, 4'h0, g, ob); pre_bad |= ob;
    if (w > 1) begin
      xfer(8'h00, w, 4'h0, g, ob); pre_bad |= ob;
    end
    chk(!pre_bad, tag, 32'(pre_bad), 32'h0);
    for (int i = 0; i < 256; i++) begin
      tx_data = 8'(i + 1);
      xfer(8'h00, w, mask_of(w), g, ob);
      chk(g == 8'(i), tag, 32'(g), 32'(i));
      chk(!ob, tag, 32'(ob), 32'h0);
    end
    cs_end();
    tx_valid = 1'b0;
  endtask

  task automatic sweep_rx(input int w, input string tag);
    fbuf[0] = 8'h03;
    for (int i = 0; i < 256; i++) fbuf[i+1] = 8'(i);
    flen = 257;
    write_frame(w, tag);
  endtask

  task automatic one_byte(input logic [7:0] b, input int w, input string tag);
    fbuf[0] = b;
    flen = 1;
    write_frame(w, tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [3:0] o, e;
    logic [7:0] g;
    logic ob;
    int base;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; lane_in = 4'h0;
    tx_valid = 1'b0; tx_data = 8'h00;
    repeat (4) @(negedge clk);
    chk(lane_mode == 2'd0, "R1 mode in reset", 32'(lane_mode), 32'h0);
    chk(lane_oe == 4'h0, "R1 oe in reset", 32'(lane_oe), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(lane_mode == 2'd0, "R1 mode after reset", 32'(lane_mode), 32'h0);
    chk(!rx_valid, "R1 rx_valid after reset", 32'(rx_valid), 32'h0);

    // R2: one-lane receive sweep
    sweep_rx(1, "R2");
    // R4: command values in a later byte do nothing
    fbuf[0] = 8'h02; fbuf[1] = 8'h3B; fbuf[2] = 8'h38; flen = 3;
    write_frame(1, "R4");
    chk(lane_mode == 2'd0, "R4 later byte", 32'(lane_mode), 32'h0);
    // R5: exit command at one lane is harmless
    one_byte(8'hFF, 1, "R5");
    chk(lane_mode == 2'd0, "R5 exit at one lane", 32'(lane_mode), 32'h0);
    // R8: one-lane read sweep
    read_frame(1, "R8");
    // R4: enter two lanes
    one_byte(8'h3B, 1, "R4");
    chk(lane_mode == 2'd1, "R4 enter two lanes", 32'(lane_mode), 32'h1);
    repeat (20) @(negedge clk);
    chk(lane_mode == 2'd1, "R6 width kept while deselected", 32'(lane_mode), 32'h1);
    // R3 and R6: two-lane receive sweep in a new frame
    sweep_rx(2, "R3 R6");
    // R5: other mode commands ignored while wide
    one_byte(8'h38, 2, "R5");
    chk(lane_mode == 2'd1, "R5 0x38 while wide", 32'(lane_mode), 32'h1);
    one_byte(8'h3B, 2, "R5");
    chk(lane_mode == 2'd1, "R5 0x3B while wide", 32'(lane_mode), 32'h1);
    // R9: two-lane read with dummy slot
    read_frame(2, "R9");
    // R10: two-lane write drives nothing
    fbuf[0] = 8'h02; fbuf[1] = 8'h00; fbuf[2] = 8'h10;
    fbuf[3] = 8'hC3; fbuf[4] = 8'h5A; flen = 5;
    write_frame(2, "R10");
    // R7: partial byte then exit at two lanes
    base = rx_total;
    cs_begin();
    pulse(4'h3, o, e);
    pulse(4'h1, o, e);
    cs_end();
    chk(rx_total == base, "R7 partial byte strobed", 32'(rx_total - base), 32'h0);
    one_byte(8'hFF, 2, "R7");
    chk(lane_mode == 2'd0, "R5 exit from two lanes", 32'(lane_mode), 32'h0);
    // R4: enter four lanes
    one_byte(8'h38, 1, "R4");
    chk(lane_mode == 2'd2, "R4 enter four lanes", 32'(lane_mode), 32'h2);
    sweep_rx(4, "R3");
    read_frame(4, "R9");
    // R7: deselect in the middle of a read
    tx_valid = 1'b1;
    tx_data = 8'h5A;
    cs_begin();
    xfer(8'h03, 4, 4'h0, g, ob);
    xfer(8'h00, 4, 4'h0, g, ob);
    xfer(8'h40, 4, 4'h0, g, ob);
    xfer(8'h00, 4, 4'h0, g, ob);
    pulse(4'h0, o, e);
    chk(e == 4'hF, "R9 four-lane enable", 32'(e), 32'hF);
    chk(o == 4'h5, "R3 upper nibble first", 32'(o), 32'h5);
    cs_n = 1'b1;
    @(negedge clk);
    chk(lane_oe == 4'h0, "R7 release on deselect", 32'(lane_oe), 32'h0);
    repeat (4) @(negedge clk);
    tx_valid = 1'b0;
    // R7: partial four-lane byte, then exit realigned
    cs_begin();
    pulse(4'h3, o, e);
    cs_end();
    one_byte(8'hFF, 4, "R7");
    chk(lane_mode == 2'd0, "R5 exit from four lanes", 32'(lane_mode), 32'h0);
    one_byte(8'hA5, 1, "R2");
    summary();
    $finish;
  end

endmodule